// File: doc/BRIEF.md
# Wiper Position Register with I2C Slave Access

This block is the digital control side of a single-channel digitally controlled potentiometer. It keeps a 7-bit volatile wiper code, where code 0 puts the wiper at the low end of the resistor string and the all-ones code puts it at the high end. Positions in between increase monotonically with the code. The resistor string itself lies outside the block.

A host reaches the code over a two-wire I2C bus. The block oversamples SCL and SDA with its own system clock. It filters out short glitches and recognises START, repeated START and STOP. It pulls SDA low through an active-high output enable. The output enable goes to an open-drain pad.

The block answers one fixed 7-bit slave identifier and has one register, at address 00h. A write carries identifier, address and data. A read sets the address first, then issues a repeated START and the identifier with the read bit set. The code is presented continuously on an output. A one-cycle strobe marks every change of the code.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset the wiper code is 64 (40h), the SDA output enable is low and the change strobe is low.
- R2: A write (START, identifier byte 0101000 followed by R/W bit 0, address byte 00h, data byte, STOP) is acknowledged in the ninth clock of each of the three bytes. It loads data bits 6:0 into the wiper code. Data bit 7 has no effect.
- R3: The new code is visible at the output before the ACK clock of the data byte goes high. The change strobe is high for exactly one system cycle when the code takes a different value. It stays low when the written value equals the current code.
- R4: If the seven most significant bits of the identifier byte differ from 0101000, no byte is acknowledged. The code is left unchanged and the block ignores the bus until the next START.
- R5: If the address byte is not 00h, it is not acknowledged. The data byte that follows is neither acknowledged nor written.
- R6: A read (START, identifier with R/W 0, address 00h, repeated START, identifier with R/W 1) acknowledges all three bytes. The block then transmits the wiper code MSB first, with bit 7 sent as 0.
- R7: While the master acknowledges in the ninth clock, the block sends the code again. After a master NACK it releases SDA and stays off the bus until STOP or START.
- R8: An identifier with R/W 1 is not acknowledged unless an address phase with 00h was acknowledged earlier in the same transaction (since the last STOP).
- R9: A STOP or START that arrives before the last data bit aborts the transaction. The code is left unchanged. A START always restarts identifier reception.
- R10: A pulse on SCL or SDA that lasts fewer than FILTER_CYCLES system clocks is rejected and does not disturb a transfer.
- R11: In a write, any byte after the data byte is not acknowledged and does not change the code.
- R12: The SDA output enable changes only while the filtered SCL is low. The only exception is the release caused by START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| wiper_code | output | WIPER_W (7) | Current wiper position code |
| wiper_changed | output | 1 | One-cycle strobe when the code takes a new value |

## Verification
The bench goes after the points where a bus slave usually slips. A commit that came one edge late would show the old code during the data ACK. A missing rejection of a short SCL pulse would shift an extra bit and store a rotated value. A read that skipped the address-phase check would answer a bare read identifier. A transmitter that kept the bus after a master NACK would pull SDA low during the following clocks. Random writes with valid, wrong-address and wrong-identifier framing are interleaved with read-backs. An aborted data byte and a write of the value already held check that nothing moves, and that no strobe fires when it should not.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ID,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_IGNORE
    } phase_e;

    localparam int BYTE_BITS = 8;
    localparam int ACK_SLOT  = 9;

endpackage

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
    parameter int   FILTER_CYCLES = 6,
    parameter logic IDLE_LEVEL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level_out
);
    localparam int CW = $clog2(FILTER_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          level;
        logic [CW-1:0] run;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.sync = {f_q.sync[0], pin_in};
        if (f_q.sync[1] != f_q.level) begin
            if (f_q.run == CW'(FILTER_CYCLES - 1)) begin
                f_d.level = f_q.sync[1];
                f_d.run   = '0;
            end else begin
                f_d.run = f_q.run + 1'b1;
            end
        end else begin
            f_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{sync: {2{IDLE_LEVEL}}, level: IDLE_LEVEL, run: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign level_out = f_q.level;

    // R10: the filtered level only moves to a value the synchroniser presented
    assert_level_follows_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.level != $past(f_q.level)) |-> (f_q.level == $past(f_q.sync[1])));

endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } prev_t;

    prev_t p_d, p_q;

    always_comb begin
        p_d.scl_p = scl;
        p_d.sda_p = sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            p_q <= p_d;
        end
    end

    assign start_ev = p_q.scl_p && scl && p_q.sda_p && !sda;
    assign stop_ev  = p_q.scl_p && scl && !p_q.sda_p && sda;
    assign scl_rise = !p_q.scl_p && scl;
    assign scl_fall = p_q.scl_p && !scl;

endmodule

// File: rtl/wiper_protocol_fsm.sv
module wiper_protocol_fsm
    import wiper_i2c_pkg::*;
#(
    parameter int         WIPER_W    = 7,
    parameter logic [6:0] SLAVE_ID   = 7'h28,
    parameter logic [7:0] REG_ADDR   = 8'h00,
    parameter int         RESET_CODE = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_level,
    input  logic               sda_level,
    input  logic               start_ev,
    input  logic               stop_ev,
    input  logic               scl_rise,
    input  logic               scl_fall,
    output logic               sda_oe,
    output logic [WIPER_W-1:0] wiper,
    output logic               changed
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);
    localparam logic [3:0] ACK_BIT  = 4'(ACK_SLOT);

    typedef struct packed {
        phase_e             state;
        phase_e             nxt;
        logic [3:0]         cnt;
        logic [7:0]         rx;
        logic [7:0]         tx;
        logic               oe;
        logic               addr_ok;
        logic               mack;
        logic [WIPER_W-1:0] wiper;
        logic               changed;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [7:0] tx_word;

    assign tx_word = 8'(c_q.wiper);

    always_comb begin
        c_d         = c_q;
        c_d.changed = 1'b0;
        if (stop_ev) begin
            c_d.state   = PH_IDLE;
            c_d.oe      = 1'b0;
            c_d.addr_ok = 1'b0;
            c_d.cnt     = '0;
        end else if (start_ev) begin
            c_d.state = PH_ID;
            c_d.oe    = 1'b0;
            c_d.cnt   = '0;
        end else if (scl_rise) begin
            case (c_q.state)
                PH_ID, PH_ADDR, PH_WDATA: begin
                    if (c_q.cnt < LAST_BIT) c_d.rx = {c_q.rx[6:0], sda_level};
                    if (c_q.cnt < ACK_BIT)  c_d.cnt = c_q.cnt + 1'b1;
                end
                PH_RDATA: begin
                    if (c_q.cnt == LAST_BIT) c_d.mack = !sda_level;
                    if (c_q.cnt < ACK_BIT)   c_d.cnt = c_q.cnt + 1'b1;
                end
                default: ;
            endcase
        end else if (scl_fall) begin
            case (c_q.state)
                PH_ID, PH_ADDR, PH_WDATA: begin
                    if (c_q.cnt == LAST_BIT) begin
                        c_d.oe = 1'b1;
                        case (c_q.state)
                            PH_ID: begin
                                if (c_q.rx[7:1] == SLAVE_ID && (!c_q.rx[0] || c_q.addr_ok)) begin
                                    c_d.nxt = c_q.rx[0] ? PH_RDATA : PH_ADDR;
                                end else begin
                                    c_d.oe    = 1'b0;
                                    c_d.state = PH_IGNORE;
                                end
                            end
                            PH_ADDR: begin
                                if (c_q.rx == REG_ADDR) begin
                                    c_d.addr_ok = 1'b1;
                                    c_d.nxt     = PH_WDATA;
                                end else begin
                                    c_d.oe    = 1'b0;
                                    c_d.state = PH_IGNORE;
                                end
                            end
                            default: begin
                                c_d.wiper   = c_q.rx[WIPER_W-1:0];
                                c_d.changed = (c_q.rx[WIPER_W-1:0] != c_q.wiper);
                                c_d.nxt     = PH_IGNORE;
                            end
                        endcase
                    end else if (c_q.cnt == ACK_BIT) begin
                        c_d.oe    = 1'b0;
                        c_d.cnt   = '0;
                        c_d.state = c_q.nxt;
                        if (c_q.nxt == PH_RDATA) begin
                            c_d.tx = tx_word;
                            c_d.oe = !tx_word[7];
                        end
                    end
                end
                PH_RDATA: begin
                    if (c_q.cnt >= 4'd1 && c_q.cnt < LAST_BIT) begin
                        c_d.oe = !c_q.tx[3'd7 - c_q.cnt[2:0]];
                    end else if (c_q.cnt == LAST_BIT) begin
                        c_d.oe = 1'b0;
                    end else if (c_q.cnt == ACK_BIT) begin
                        c_d.cnt = '0;
                        if (c_q.mack) begin
                            c_d.tx = tx_word;
                            c_d.oe = !tx_word[7];
                        end else begin
                            c_d.oe    = 1'b0;
                            c_d.state = PH_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: PH_IDLE, nxt: PH_IDLE, cnt: '0, rx: '0, tx: '0, oe: 1'b0,
                     addr_ok: 1'b0, mack: 1'b0, wiper: WIPER_W'(RESET_CODE), changed: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe  = c_q.oe;
    assign wiper   = c_q.wiper;
    assign changed = c_q.changed;

    // R12: the output enable only moves while SCL is low, or on a START/STOP release
    assert_oe_moves_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.oe != $past(c_q.oe)) |-> (!scl_level || $past(start_ev || stop_ev)));

    // R3: the code can only move out of the data-byte phase
    assert_code_from_data_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.wiper != $past(c_q.wiper)) |-> ($past(c_q.state) == PH_WDATA));

    // R4: no bus drive while ignoring
    assert_ignore_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == PH_IGNORE) |-> !c_q.oe);

    // R9: any START restarts identifier reception
    assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (c_q.state == PH_ID && c_q.cnt == 4'd0));

    // R2: bit counter stays within the byte plus acknowledge slot
    assert_bitcount_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= ACK_BIT);

endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
    parameter int         FILTER_CYCLES = 6,
    parameter int         WIPER_W       = 7,
    parameter logic [6:0] SLAVE_ID      = 7'h28,
    parameter logic [7:0] REG_ADDR      = 8'h00,
    parameter int         RESET_CODE    = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    output logic [WIPER_W-1:0] wiper_code,
    output logic               wiper_changed
);
    localparam int N_PINS = 2;

    logic [N_PINS-1:0] raw_pins;
    logic [N_PINS-1:0] clean_pins;
    logic start_ev, stop_ev, scl_rise, scl_fall;

    assign raw_pins = {sda_in, scl_in};

    for (genvar g = 0; g < N_PINS; g++) begin : g_filt
        pin_deglitch #(
            .FILTER_CYCLES (FILTER_CYCLES),
            .IDLE_LEVEL    (1'b1)
        ) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_in    (raw_pins[g]),
            .level_out (clean_pins[g])
        );
    end

    i2c_line_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (clean_pins[0]),
        .sda      (clean_pins[1]),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    wiper_protocol_fsm #(
        .WIPER_W    (WIPER_W),
        .SLAVE_ID   (SLAVE_ID),
        .REG_ADDR   (REG_ADDR),
        .RESET_CODE (RESET_CODE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_level (clean_pins[0]),
        .sda_level (clean_pins[1]),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_oe    (sda_oe),
        .wiper     (wiper_code),
        .changed   (wiper_changed)
    );

endmodule

// File: tb/tb_wiper_i2c_slave.sv
module tb_wiper_i2c_slave;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic [6:0] wiper_code;
    logic wiper_changed;
    wire  sda_line = !(m_low || sda_oe);

    int checks = 0, fails = 0, pulses = 0, exp_pulses = 0, oe_moves = 0;
    logic [6:0] exp_w = 7'd64;
    logic [6:0] w_seen;
    bit done = 0;

    always #4 clk = ~clk;

    wiper_i2c_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .wiper_code(wiper_code), .wiper_changed(wiper_changed)
    );

    always @(posedge clk) if (rst_n && wiper_changed) pulses <= pulses + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start;
        m_low = 0; wq(Q); scl = 1; wq(Q); m_low = 1; wq(Q); scl = 0; wq(Q);
    endtask

    task automatic bus_stop;
        m_low = 1; wq(Q); scl = 1; wq(Q); m_low = 0; wq(Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        m_low = !b;
        if (glitch) begin wq(Q/2); scl = 1; wq(3); scl = 0; wq(Q - Q/2 - 3); end
        else wq(Q);
        scl = 1; wq(2*Q); scl = 0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        logic oe_a;
        m_low = 0; wq(Q); scl = 1; wq(2); oe_a = sda_oe; wq(Q-2);
        b = sda_line; w_seen = wiper_code; wq(Q-2);
        if (sda_oe !== oe_a) oe_moves++;
        wq(2); scl = 0; wq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, input int glitch_at, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i], i == glitch_at);
        recv_bit(b); acked = !b;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
        send_bit(!mack, 0);
    endtask

    function automatic logic [3:0] write_acks(input logic [7:0] id8, input logic [7:0] adr);
        if (id8 != 8'h50) return 4'b0000;
        if (adr != 8'h00) return 4'b0001;
        return 4'b0111;
    endfunction

    task automatic do_write(input string req, input logic [7:0] id8, input logic [7:0] adr,
                            input logic [7:0] dat, input int glitch_at);
        logic a0, a1, a2;
        logic [3:0] e;
        e = write_acks(id8, adr);
        bus_start; wr_byte(id8, -1, a0); wr_byte(adr, -1, a1); wr_byte(dat, glitch_at, a2);
        bus_stop; wq(4);
        chk({req, " acks"}, {29'd0, a2, a1, a0}, {28'd0, e});
        if (e == 4'b0111) begin
            chk("R3 code visible at data ACK", w_seen, dat[6:0]);
            if (dat[6:0] != exp_w) exp_pulses++;
            exp_w = dat[6:0];
        end
        chk({req, " code"}, wiper_code, exp_w);
        chk("R3 strobe count", pulses, exp_pulses);
    endtask

    task automatic do_read(input int nbytes);
        logic a0, a1, a2, b;
        logic [7:0] v;
        bus_start; wr_byte(8'h50, -1, a0); wr_byte(8'h00, -1, a1);
        bus_start; wr_byte(8'h51, -1, a2);
        chk("R6 read acks", {a2, a1, a0}, 3'b111);
        for (int k = 0; k < nbytes; k++) begin
            rd_byte(k != nbytes - 1, v);
            chk("R6 R7 read data", v, {1'b0, exp_w});
        end
        for (int k = 0; k < 9; k++) begin
            recv_bit(b);
            chk("R7 released after NACK", b, 1'b1);
        end
        bus_stop; wq(4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a0, a1, a2, a3;
        logic [7:0] v;
        void'($urandom(32'd20240611));
        wq(5); rst_n = 1; wq(5);
        chk("R1 reset code", wiper_code, 7'd64);
        chk("R1 reset oe", sda_oe, 1'b0);
        chk("R1 reset strobe", pulses, 0);

        do_write("R2 write", 8'h50, 8'h00, 8'h15, -1);
        do_write("R2 bit7 ignored", 8'h50, 8'h00, 8'h95, -1);
        do_write("R2 top code", 8'h50, 8'h00, 8'h7F, -1);
        do_write("R2 bottom code", 8'h50, 8'h00, 8'h00, -1);
        do_write("R4 wrong id", 8'h52, 8'h00, 8'h33, -1);
        do_write("R5 wrong addr", 8'h50, 8'h01, 8'h33, -1);
        do_write("R10 SCL glitch", 8'h50, 8'h00, 8'h5A, 3);
        do_read(3);

        // R8: read identifier without address phase
        bus_start; wr_byte(8'h51, -1, a0); bus_stop; wq(4);
        chk("R8 bare read NACK", a0, 1'b0);

        // R9: STOP mid data byte
        bus_start; wr_byte(8'h50, -1, a0); wr_byte(8'h00, -1, a1);
        for (int i = 7; i >= 3; i--) send_bit(1'b1, 0);
        bus_stop; wq(4);
        chk("R9 abort by STOP", wiper_code, exp_w);
        // R9: START mid data byte, then a full write
        bus_start; wr_byte(8'h50, -1, a0); wr_byte(8'h00, -1, a1);
        for (int i = 7; i >= 4; i--) send_bit(1'b0, 0);
        wq(4);
        chk("R9 abort by START", wiper_code, exp_w);
        bus_start; wr_byte(8'h50, -1, a0); wr_byte(8'h00, -1, a1); wr_byte(8'h21, -1, a2);
        // R11: extra byte after data
        wr_byte(8'h44, -1, a3); bus_stop; wq(4);
        chk("R9 restart acks", {a2, a1, a0}, 3'b111);
        chk("R11 extra byte NACK", a3, 1'b0);
        if (exp_w != 7'h21) exp_pulses++;
        exp_w = 7'h21;
        chk("R11 code after extra", wiper_code, exp_w);

        for (int it = 0; it < 14; it++) begin
            int kind;
            logic [7:0] idb, adr;
            kind = $urandom % 4;
            idb = 8'h50; adr = 8'h00;
            if (kind == 2) adr = 8'(1 + ($urandom % 255));
            if (kind == 3) begin
                idb = {7'($urandom), 1'b0};
                if (idb == 8'h50) idb = 8'h52;
            end
            do_write("R2 R4 R5 random", idb, adr, 8'($urandom), -1);
            if (it % 5 == 4) do_read(1);
        end

        chk("R12 oe stable while SCL high", oe_moves, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule